// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register

This block is an eight-stage shift register that is loaded in parallel and read out serially. It runs on a fast system clock. A slow external shift clock and a clock-inhibit line arrive as asynchronous pins, and so do a load control, a serial input and the parallel data. Every pin is resynchronized. The OR of the two clock pins is then watched for a rising edge, and each rising edge advances the register by one stage. Because the two clock pins are ORed, either one can serve as the clock while the other serves as the inhibit.

While the load control is low, the parallel word is written into the stages on every cycle, and the clock pins are ignored. When the load control goes high, the register either shifts or holds. Each shift moves the serial input into the first stage, moves every other stage up by one, and drops the old last stage. The last stage is driven out both true and inverted.

Top module: `pload_shifter`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0, so `q_last` reads 0 and `q_last_n` reads 1. Reset also clears the edge history and returns the synchronizers to their idle values: load control high, clock pins low.
- R2: While the synchronized `load_n` is low, each stage takes its `par_in` bit on every system cycle. Bit 0 is the first stage and bit WIDTH-1 is the last stage, so `q_last` equals `par_in[WIDTH-1]`. `sclk`, `sinh` and `ser_in` have no effect during this time.
- R3: Load has priority over a shift strobe in the same cycle. Edge history keeps updating during load, so releasing load while the OR of the clocks is already high causes no shift.
- R4: With `load_n` high and `sinh` low, a rising `sclk` shifts by one. `ser_in` enters stage 0, each stage i takes stage i-1, and `q_last` takes the old stage WIDTH-2.
- R5: With `load_n` high and `sclk` low, a rising `sinh` shifts exactly as in R4.
- R6: With `load_n` high and one clock pin held high, any activity on the other clock pin leaves every stage unchanged.
- R7: `q_last_n` is always the complement of `q_last`.
- R8: A pin change takes effect at the outputs on the third rising system clock edge after it is applied: two edges for synchronization and one for the register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Low = parallel load, high = shift/hold (asynchronous) |
| sclk | input | 1 | External shift clock (asynchronous) |
| sinh | input | 1 | Clock inhibit; interchangeable with sclk (asynchronous) |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel data, bit 0 to stage 0 |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Complement of last stage |

## Verification
The parallel word is loaded while both clock pins toggle and the serial input changes. This shows that load overrides everything else. Load is then released with a clock pin high, which tells a correct edge history apart from a detector that stops updating during load. Shifts are driven first by `sclk` and then by `sinh`, each with a different serial pattern, so an error in clock ORing or in stage order shows up as wrong bits at the output. Finally, one clock pin is held high while the other toggles, which separates a true inhibit from a plain rising-edge detector on a single pin.

// File: rtl/pload_shifter.sv
module pload_shifter #(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             sclk,
  input  logic             sinh,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_last,
  output logic             q_last_n
);
  localparam int LAST = WIDTH - 1;
  localparam int SL   = SYNC_DEPTH - 1;

  logic [SL:0]    ld_pipe, ck_pipe, ih_pipe, sr_pipe;
  logic [LAST:0]  par_pipe [SYNC_DEPTH];
  logic [LAST:0]  stages;
  logic           or_d;

  logic           ld_s, ck_s, ih_s, ser_s, or_s, strobe;
  logic [LAST:0]  par_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_pipe <= '1;
      ck_pipe <= '0;
      ih_pipe <= '0;
      sr_pipe <= '0;
      for (int i = 0; i < SYNC_DEPTH; i++) par_pipe[i] <= '0;
    end else begin
      ld_pipe     <= {ld_pipe[SL:0], load_n} >> 0;
      ck_pipe     <= {ck_pipe[SL:0], sclk} >> 0;
      ih_pipe     <= {ih_pipe[SL:0], sinh} >> 0;
      sr_pipe     <= {sr_pipe[SL:0], ser_in} >> 0;
      par_pipe[0] <= par_in;
      for (int i = 1; i < SYNC_DEPTH; i++) par_pipe[i] <= par_pipe[i-1];
    end
  end

  assign ld_s   = ld_pipe[SL];
  assign ck_s   = ck_pipe[SL];
  assign ih_s   = ih_pipe[SL];
  assign ser_s  = sr_pipe[SL];
  assign par_s  = par_pipe[SL];
  assign or_s   = ck_s | ih_s;
  assign strobe = or_s & ~or_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      stages <= '0;
      or_d   <= 1'b0;
    end else begin
      or_d <= or_s;
      if (!ld_s)       stages <= par_s;
      else if (strobe) stages <= {stages[LAST-1:0], ser_s};
    end
  end

  assign q_last   = stages[LAST];
  assign q_last_n = ~stages[LAST];
endmodule

// File: rtl/pload_shifter_chk.sv
module pload_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_s,
  input logic             ck_s,
  input logic             ih_s,
  input logic             ser_s,
  input logic [WIDTH-1:0] par_s,
  input logic [WIDTH-1:0] stages,
  input logic             q_last,
  input logic             q_last_n
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (stages == '0));

  a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
    !ld_s |=> (stages == $past(par_s)));

  a_r4_shift_step: assert property (@(posedge clk) disable iff (rst)
    (ld_s && !$past(ck_s | ih_s) && (ck_s | ih_s)) |=>
      (stages == {$past(stages[WIDTH-2:0]), $past(ser_s)}));

  a_r6_inhibit_holds: assert property (@(posedge clk) disable iff (rst)
    (ld_s && ih_s && $past(ih_s)) |=> $stable(stages));

  a_r3_no_edge_no_move: assert property (@(posedge clk) disable iff (rst)
    (ld_s && (ck_s | ih_s) == $past(ck_s | ih_s)) |=> $stable(stages));

  a_r7_complement: assert property (@(posedge clk) disable iff (rst)
    q_last_n != q_last);
endmodule

bind pload_shifter pload_shifter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .ld_s(ld_s), .ck_s(ck_s), .ih_s(ih_s),
  .ser_s(ser_s), .par_s(par_s), .stages(stages),
  .q_last(q_last), .q_last_n(q_last_n)
);

// File: tb/pload_shifter_tb_top.sv
module pload_shifter_tb_top;
  localparam int PERIOD = 10;
  localparam int W = 8;

  typedef struct packed {
    logic         ld;
    logic         ck;
    logic         ih;
    logic         si;
    logic [W-1:0] pd;
  } pins_t;

  logic clk = 0, rst = 1;
  logic ld_n = 1, ck = 0, ih = 0, si = 0;
  logic [W-1:0] pd = '0;
  logic q, qn;

  int checks = 0, errors = 0;
  pins_t hist[$];
  logic [W-1:0] mreg = '0;
  logic mprev = 0;

  always #(PERIOD/2) clk = ~clk;

  pload_shifter #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .load_n(ld_n), .sclk(ck), .sinh(ih),
    .ser_in(si), .par_in(pd), .q_last(q), .q_last_n(qn)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    pins_t e, cur;
    logic  o;
    cur = '{ld: ld_n, ck: ck, ih: ih, si: si, pd: pd};
    hist.push_back(cur);
    @(posedge clk);
    #1;
    e = hist.pop_front();
    o = e.ck | e.ih;
    if (!e.ld)             mreg = e.pd;
    else if (o && !mprev)  mreg = {mreg[W-2:0], e.si};
    mprev = o;
    check(tag, q, mreg[W-1]);
    check("R7", qn, ~mreg[W-1]);
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic pulse(input string tag, input bit use_inh, input logic bit_in);
    si = bit_in;
    if (use_inh) ih = 1; else ck = 1;
    run(tag, 3);
    if (use_inh) ih = 0; else ck = 0;
    run(tag, 3);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", q, 1'b0);
    check("R1", qn, 1'b1);
    @(negedge clk);
    rst = 0;
    hist.push_back('{ld: 1'b1, ck: 1'b0, ih: 1'b0, si: 1'b0, pd: '0});
    hist.push_back('{ld: 1'b1, ck: 1'b0, ih: 1'b0, si: 1'b0, pd: '0});
    run("R1", 2);

    // R2 R8: load 8'hA5 while clocks and serial toggle
    pd = 8'hA5; ld_n = 0;
    for (int i = 0; i < 8; i++) begin
      ck = i[0]; ih = i[1]; si = i[2];
      cyc("R2 R8");
    end
    // R3: release with OR-clock high, no false shift
    ck = 1; ih = 0;
    run("R2", 3);
    ld_n = 1;
    run("R3", 6);
    ck = 0;
    run("R3", 4);

    // R4: shift by sclk, pattern 1,0,1,1
    pulse("R4", 0, 1'b1);
    pulse("R4", 0, 1'b0);
    pulse("R4", 0, 1'b1);
    pulse("R4", 0, 1'b1);

    // R5: shift by sinh, pattern 0,1,0,0
    pulse("R5", 1, 1'b0);
    pulse("R5", 1, 1'b1);
    pulse("R5", 1, 1'b0);
    pulse("R5", 1, 1'b0);

    // R6: sinh high, sclk toggles, hold
    ih = 1;
    run("R6", 4);
    for (int i = 0; i < 6; i++) begin
      ck = ~ck; si = ~si;
      run("R6", 3);
    end
    ck = 0;
    run("R6", 3);
    // R6: sclk high, sinh toggles, hold
    ck = 1;
    run("R6", 3);
    ih = 0;
    for (int i = 0; i < 6; i++) begin
      ih = ~ih;
      run("R6", 3);
    end
    ih = 0; ck = 0;
    run("R6", 4);

    // R2 R4: new word, shift all stages out
    pd = 8'h3C; ld_n = 0;
    run("R2", 4);
    ld_n = 1;
    run("R2", 3);
    for (int i = 0; i < 9; i++) pulse("R4", i[0], i[1] ^ i[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule